// File: doc/BRIEF.md
# Boundary-Scan Test Access Controller with Instruction Decode

This block is the serial test-access control path of a device that carries no identification register. It holds the sixteen-state test-access state machine, an eight-bit instruction register, a one-bit bypass register, the instruction decoder and the output multiplexer for the serial test data. The boundary cells sit outside this block. The block tells them when to capture, shift and update, and it tells them whether the pins take their values from the update latches. It also raises a global signal that puts every system output into high impedance.

Reset comes from the active-low asynchronous test reset or from holding the mode-select line high. Either path leaves the bypass register between the serial input and output. When the instruction register is captured it loads a fixed eight-bit pattern, and that pattern serves as a stand-in identity code for the device. Four opcodes are decoded. Every other code gives bypass behaviour. The serial output is registered on the falling clock edge and is enabled only while a shift is in progress.

Top module: `tap_ir_top`

## Requirements
- R1: While the asynchronous reset is low, and after it is released, the output enable is 0, the mode select is 0 and the force-high-impedance output is 0. The first data scan after reset goes through the bypass register.
- R2: A Capture-IR followed by an instruction shift presents the pattern 8'b00111101 on the serial output, least significant bit first. The first bit seen is therefore 1, then 0.
- R3: Opcode 8'h00 (external test) places the boundary register on the serial path, so the serial output repeats the boundary serial input. It sets the mode select to 1 and the force-high-impedance output to 0. Each data scan gives one capture strobe, one shift strobe per shifted bit and one update strobe.
- R4: Opcode 8'h81 (sample/preload) places the boundary register on the serial path with the same strobes as R3. Both the mode select and the force-high-impedance output are 0.
- R5: Opcode 8'h82 (clamp) sets the mode select to 1 and the force-high-impedance output to 0, and places the bypass register on the serial path. No boundary strobe fires.
- R6: Opcode 8'h03 (high-impedance) sets the force-high-impedance output to 1 and the mode select to 0, and places the bypass register on the serial path. No boundary strobe fires.
- R7: Every opcode other than the four above behaves as bypass. Both controls are 0 and no boundary strobe fires.
- R8: The bypass register captures 0 in Capture-DR. While it is selected, the serial output shows 0 first and then each input bit one shift later.
- R9: The serial output enable is 1 only in Shift-IR and Shift-DR. Both the enable and the output data change on the falling clock edge.
- R10: A shifted instruction has no effect before Update-IR. It controls the very next Capture-DR, even when Update-IR goes straight to Select-DR-Scan.
- R11: Five clock cycles with mode select high reach Test-Logic-Reset from any state, including Shift-DR. The active instruction then returns to bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial test data in, sampled on the rising edge |
| bsrSerialIn | input | 1 | Serial output of the last boundary cell |
| tdo | output | 1 | Serial test data out, updated on the falling edge |
| tdoEn | output | 1 | Output enable for tdo; 0 means high impedance |
| bsrCapture | output | 1 | Boundary register capture strobe |
| bsrShift | output | 1 | Boundary register shift strobe |
| bsrUpdate | output | 1 | Boundary register update strobe |
| bsrModeSel | output | 1 | Boundary cells drive the pins from their update latches |
| forceHiZ | output | 1 | Puts all system outputs into high impedance |

## Verification
Two events can happen on the same rising edge: the instruction update at the end of Update-IR, and the choice of data path for the next scan when the controller moves straight from Update-IR to Select-DR-Scan. The bench loads external test that way and then runs a data scan with no idle cycle in between. The scan passes only if the capture, shift and update strobes all fire and the serial output follows the boundary serial input. A second case overlaps a reset with an active shift: five high mode-select cycles are clocked from inside Shift-DR while external test is active. The bench then checks that the mode select drops and that the next scan is bypass.

// File: rtl/tap_ir_pkg.sv
package tap_ir_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHF, ST_DR_EX1, ST_DR_PAU, ST_DR_EX2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHF, ST_IR_EX1, ST_IR_PAU, ST_IR_EX2, ST_IR_UPD
  } tapStateT;

  typedef struct packed {
    logic inReset;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapStrobeT;

  typedef enum logic [2:0] {
    INS_EXTEST, INS_SAMPLE, INS_CLAMP, INS_HIGHZ, INS_BYPASS
  } insClassT;

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_ir_pkg::*;
(
  input  logic      tck,
  input  logic      trstN,
  input  logic      tms,
  output tapStrobeT strb
);

  tapStateT state, nextState;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_RESET;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RESET:  nextState = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nextState = tms ? ST_DR_SEL : ST_IDLE;
      ST_DR_SEL: nextState = tms ? ST_IR_SEL : ST_DR_CAP;
      ST_DR_CAP: nextState = tms ? ST_DR_EX1 : ST_DR_SHF;
      ST_DR_SHF: nextState = tms ? ST_DR_EX1 : ST_DR_SHF;
      ST_DR_EX1: nextState = tms ? ST_DR_UPD : ST_DR_PAU;
      ST_DR_PAU: nextState = tms ? ST_DR_EX2 : ST_DR_PAU;
      ST_DR_EX2: nextState = tms ? ST_DR_UPD : ST_DR_SHF;
      ST_DR_UPD: nextState = tms ? ST_DR_SEL : ST_IDLE;
      ST_IR_SEL: nextState = tms ? ST_RESET  : ST_IR_CAP;
      ST_IR_CAP: nextState = tms ? ST_IR_EX1 : ST_IR_SHF;
      ST_IR_SHF: nextState = tms ? ST_IR_EX1 : ST_IR_SHF;
      ST_IR_EX1: nextState = tms ? ST_IR_UPD : ST_IR_PAU;
      ST_IR_PAU: nextState = tms ? ST_IR_EX2 : ST_IR_PAU;
      ST_IR_EX2: nextState = tms ? ST_IR_UPD : ST_IR_SHF;
      ST_IR_UPD: nextState = tms ? ST_DR_SEL : ST_IDLE;
      default:   nextState = ST_RESET;
    endcase
  end

  always_comb begin
    strb.inReset   = (state == ST_RESET);
    strb.captureIr = (state == ST_IR_CAP);
    strb.shiftIr   = (state == ST_IR_SHF);
    strb.updateIr  = (state == ST_IR_UPD);
    strb.captureDr = (state == ST_DR_CAP);
    strb.shiftDr   = (state == ST_DR_SHF);
    strb.updateDr  = (state == ST_DR_UPD);
  end

endmodule

// File: rtl/tap_ir_decode.sv
module tap_ir_decode
  import tap_ir_pkg::*;
#(
  parameter int                  IR_WIDTH  = 8,
  parameter logic [IR_WIDTH-1:0] OP_EXTEST = 8'h00,
  parameter logic [IR_WIDTH-1:0] OP_SAMPLE = 8'h81,
  parameter logic [IR_WIDTH-1:0] OP_CLAMP  = 8'h82,
  parameter logic [IR_WIDTH-1:0] OP_HIGHZ  = 8'h03
) (
  input  logic [IR_WIDTH-1:0] irCode,
  input  logic                inReset,
  output insClassT            insClass
);

  always_comb begin
    if (inReset)                  insClass = INS_BYPASS;
    else if (irCode == OP_EXTEST) insClass = INS_EXTEST;
    else if (irCode == OP_SAMPLE) insClass = INS_SAMPLE;
    else if (irCode == OP_CLAMP)  insClass = INS_CLAMP;
    else if (irCode == OP_HIGHZ)  insClass = INS_HIGHZ;
    else                          insClass = INS_BYPASS;
  end

endmodule

// File: rtl/tap_datapath.sv
module tap_datapath
  import tap_ir_pkg::*;
#(
  parameter int                  IR_WIDTH   = 8,
  parameter logic [IR_WIDTH-1:0] IR_CAPTURE = 8'b0011_1101,
  parameter logic [IR_WIDTH-1:0] OP_EXTEST  = 8'h00,
  parameter logic [IR_WIDTH-1:0] OP_SAMPLE  = 8'h81,
  parameter logic [IR_WIDTH-1:0] OP_CLAMP   = 8'h82,
  parameter logic [IR_WIDTH-1:0] OP_HIGHZ   = 8'h03
) (
  input  logic      tck,
  input  logic      trstN,
  input  tapStrobeT strb,
  input  logic      tdi,
  input  logic      bsrSerialIn,
  output logic      tdo,
  output logic      tdoEn,
  output logic      bsrCapture,
  output logic      bsrShift,
  output logic      bsrUpdate,
  output logic      bsrModeSel,
  output logic      forceHiZ
);

  localparam logic [IR_WIDTH-1:0] OP_RESET = '1;

  logic [IR_WIDTH-1:0] irShiftReg;
  logic [IR_WIDTH-1:0] irActive;
  logic                bypassReg;
  logic                selBsr;
  insClassT            insClass;

  tap_ir_decode #(
    .IR_WIDTH (IR_WIDTH),
    .OP_EXTEST(OP_EXTEST),
    .OP_SAMPLE(OP_SAMPLE),
    .OP_CLAMP (OP_CLAMP),
    .OP_HIGHZ (OP_HIGHZ)
  ) u_decode (
    .irCode  (irActive),
    .inReset (strb.inReset),
    .insClass(insClass)
  );

  // instruction shift stage and active instruction
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShiftReg <= IR_CAPTURE;
      irActive   <= OP_RESET;
    end else begin
      if (strb.captureIr)    irShiftReg <= IR_CAPTURE;
      else if (strb.shiftIr) irShiftReg <= {tdi, irShiftReg[IR_WIDTH-1:1]};
      if (strb.inReset)      irActive <= OP_RESET;
      else if (strb.updateIr) irActive <= irShiftReg;
    end
  end

  // single-stage bypass register
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              bypassReg <= 1'b0;
    else if (strb.captureDr) bypassReg <= 1'b0;
    else if (strb.shiftDr)   bypassReg <= tdi;
  end

  assign selBsr     = (insClass == INS_EXTEST) || (insClass == INS_SAMPLE);
  assign bsrModeSel = (insClass == INS_EXTEST) || (insClass == INS_CLAMP);
  assign forceHiZ   = (insClass == INS_HIGHZ);
  assign bsrCapture = strb.captureDr && selBsr;
  assign bsrShift   = strb.shiftDr   && selBsr;
  assign bsrUpdate  = strb.updateDr  && selBsr;

  // serial output, retimed on the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= strb.shiftIr || strb.shiftDr;
      if (strb.shiftIr)      tdo <= irShiftReg[0];
      else if (strb.shiftDr) tdo <= selBsr ? bsrSerialIn : bypassReg;
      else                   tdo <= 1'b0;
    end
  end

endmodule

// File: rtl/tap_ir_top.sv
module tap_ir_top
  import tap_ir_pkg::*;
#(
  parameter int                  IR_WIDTH   = 8,
  parameter logic [IR_WIDTH-1:0] IR_CAPTURE = 8'b0011_1101,
  parameter logic [IR_WIDTH-1:0] OP_EXTEST  = 8'h00,
  parameter logic [IR_WIDTH-1:0] OP_SAMPLE  = 8'h81,
  parameter logic [IR_WIDTH-1:0] OP_CLAMP   = 8'h82,
  parameter logic [IR_WIDTH-1:0] OP_HIGHZ   = 8'h03
) (
  input  logic tck,
  input  logic trstN,
  input  logic tms,
  input  logic tdi,
  input  logic bsrSerialIn,
  output logic tdo,
  output logic tdoEn,
  output logic bsrCapture,
  output logic bsrShift,
  output logic bsrUpdate,
  output logic bsrModeSel,
  output logic forceHiZ
);

  tapStrobeT strb;

  tap_ctrl u_ctrl (
    .tck  (tck),
    .trstN(trstN),
    .tms  (tms),
    .strb (strb)
  );

  tap_datapath #(
    .IR_WIDTH  (IR_WIDTH),
    .IR_CAPTURE(IR_CAPTURE),
    .OP_EXTEST (OP_EXTEST),
    .OP_SAMPLE (OP_SAMPLE),
    .OP_CLAMP  (OP_CLAMP),
    .OP_HIGHZ  (OP_HIGHZ)
  ) u_dp (
    .tck        (tck),
    .trstN      (trstN),
    .strb       (strb),
    .tdi        (tdi),
    .bsrSerialIn(bsrSerialIn),
    .tdo        (tdo),
    .tdoEn      (tdoEn),
    .bsrCapture (bsrCapture),
    .bsrShift   (bsrShift),
    .bsrUpdate  (bsrUpdate),
    .bsrModeSel (bsrModeSel),
    .forceHiZ   (forceHiZ)
  );

endmodule

// File: rtl/tap_ir_checker.sv
module tap_ir_checker (
  input logic tck,
  input logic trstN,
  input logic tms,
  input logic tdoEn,
  input logic bsrCapture,
  input logic bsrShift,
  input logic bsrUpdate,
  input logic bsrModeSel,
  input logic forceHiZ
);

  // R3: the boundary strobes never overlap
  assert_strobe_onehot_R3: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({bsrCapture, bsrShift, bsrUpdate}));

  // R3: a capture is never followed directly by another capture or an update
  assert_capture_then_shift_R3: assert property (@(posedge tck) disable iff (!trstN)
    bsrCapture |=> (!bsrCapture && !bsrUpdate));

  // R3: the update strobe lasts one cycle
  assert_update_single_R3: assert property (@(posedge tck) disable iff (!trstN)
    bsrUpdate |=> !bsrUpdate);

  // R5 / R6: clamp and high-impedance never both active
  assert_mode_exclusive_R6: assert property (@(posedge tck) disable iff (!trstN)
    !(bsrModeSel && forceHiZ));

  // R9: while the boundary register shifts, the serial output is enabled
  assert_shift_drives_tdo_R9: assert property (@(posedge tck) disable iff (!trstN)
    bsrShift |-> tdoEn);

  // R11: five high mode-select samples reach reset with bypass active
  assert_tms_reset_R11: assert property (@(posedge tck) disable iff (!trstN)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (!bsrModeSel && !forceHiZ && !tdoEn));

endmodule

bind tap_ir_top tap_ir_checker u_chk (
  .tck       (tck),
  .trstN     (trstN),
  .tms       (tms),
  .tdoEn     (tdoEn),
  .bsrCapture(bsrCapture),
  .bsrShift  (bsrShift),
  .bsrUpdate (bsrUpdate),
  .bsrModeSel(bsrModeSel),
  .forceHiZ  (forceHiZ)
);

// File: tb/tap_ir_top_tb.sv
module tap_ir_top_tb;

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic bsrSerialIn = 1'b0;
  logic tdo, tdoEn, bsrCapture, bsrShift, bsrUpdate, bsrModeSel, forceHiZ;

  int nChk = 0;
  int nBad = 0;
  int capCnt = 0, shfCnt = 0, updCnt = 0;
  logic expShift = 1'b0;
  logic monOn = 1'b0;
  string curReq = "R1";
  logic expQ[$];

  always #10 tck = ~tck;

  tap_ir_top u_dut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .bsrSerialIn(bsrSerialIn),
    .tdo(tdo), .tdoEn(tdoEn), .bsrCapture(bsrCapture), .bsrShift(bsrShift),
    .bsrUpdate(bsrUpdate), .bsrModeSel(bsrModeSel), .forceHiZ(forceHiZ)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: samples just before each rising edge, after the falling-edge update
  initial begin
    forever begin
      @(negedge tck);
      #8;
      if (monOn) begin
        chk("R9 tdoEn", {31'd0, tdoEn}, {31'd0, expShift});
        if (tdoEn) begin
          if (expQ.size() == 0) chk({curReq, " unexpected tdo bit"}, 1, 0);
          else chk({curReq, " tdo"}, {31'd0, tdo}, {31'd0, expQ.pop_front()});
        end
        capCnt += int'(bsrCapture);
        shfCnt += int'(bsrShift);
        updCnt += int'(bsrUpdate);
      end
    end
  end

  task automatic step(input logic m, input logic d, input logic shiftAfter);
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
    expShift = shiftAfter;
  endtask

  // from idle: scan an instruction; leaves the controller in Exit1-IR
  task automatic shiftIr(input logic [7:0] val, input string req);
    curReq = req;
    for (int i = 0; i < 8; i++) expQ.push_back(1'(8'b0011_1101 >> i));
    step(1, 0, 0); step(1, 0, 0); step(0, 0, 0); step(0, 0, 1);
    for (int i = 0; i < 8; i++) step(i == 7, val[i], i != 7);
  endtask

  task automatic loadIr(input logic [7:0] val, input string req);
    shiftIr(val, req);
    step(1, 0, 0); step(0, 0, 0);
  endtask

  // data scan; fromSel means the controller already sits in Select-DR-Scan
  task automatic shiftDr(input int n, input logic [15:0] data, input logic bsrPath,
                         input logic bsrVal, input logic fromSel, input string req);
    curReq = req;
    bsrSerialIn = bsrVal;
    capCnt = 0; shfCnt = 0; updCnt = 0;
    for (int i = 0; i < n; i++)
      expQ.push_back(bsrPath ? bsrVal : ((i == 0) ? 1'b0 : data[i-1]));
    if (!fromSel) step(1, 0, 0);
    step(0, 0, 0); step(0, 0, 1);
    for (int i = 0; i < n; i++) step(i == n - 1, data[i], i != n - 1);
    step(1, 0, 0); step(0, 0, 0);
    #2;
    chk({req, " queue drained"}, expQ.size(), 0);
    chk({req, " capture strobes"}, capCnt, bsrPath ? 1 : 0);
    chk({req, " shift strobes"}, shfCnt, bsrPath ? n : 0);
    chk({req, " update strobes"}, updCnt, bsrPath ? 1 : 0);
  endtask

  task automatic chkModes(input logic ms, input logic hz, input string req);
    #4;
    chk({req, " modeSel"}, {31'd0, bsrModeSel}, {31'd0, ms});
    chk({req, " forceHiZ"}, {31'd0, forceHiZ}, {31'd0, hz});
  endtask

  initial begin
    #(200000 * 20);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [7:0] others [4];
    others[0] = 8'h55; others[1] = 8'h01; others[2] = 8'h80; others[3] = 8'hFF;

    // R1: reset state
    repeat (3) @(posedge tck);
    #5;
    chk("R1 tdoEn in reset", {31'd0, tdoEn}, 0);
    chkModes(0, 0, "R1 reset");
    @(negedge tck);
    trstN = 1'b1;
    monOn = 1'b1;
    step(0, 0, 0);
    chkModes(0, 0, "R1 after release");
    shiftDr(6, 16'b10_1101, 0, 1, 0, "R1 R8 bypass after reset");

    // R2 + R10: external test shifted, not active until Update-IR
    shiftIr(8'h00, "R2 capture pattern");
    chkModes(0, 0, "R10 before update");
    step(1, 0, 0); step(0, 0, 0);
    chkModes(1, 0, "R3 extest");
    shiftDr(5, 16'b0_1010, 1, 1, 0, "R3 extest ones");
    shiftDr(4, 16'b1111, 1, 0, 0, "R3 extest zeros");

    loadIr(8'h81, "R4 load");
    chkModes(0, 0, "R4 sample");
    shiftDr(5, 16'b1_0011, 1, 1, 0, "R4 sample scan");

    loadIr(8'h82, "R5 load");
    chkModes(1, 0, "R5 clamp");
    shiftDr(7, 16'b110_0101, 0, 1, 0, "R5 clamp bypass");

    loadIr(8'h03, "R6 load");
    chkModes(0, 1, "R6 highz");
    shiftDr(5, 16'b0_1101, 0, 1, 0, "R6 highz bypass");

    foreach (others[k]) begin
      loadIr(others[k], "R7 load");
      chkModes(0, 0, "R7 other opcode");
      shiftDr(4, 16'b1011, 0, 1, 0, "R7 R8 other bypass");
    end

    // R10: Update-IR straight into Select-DR-Scan
    shiftIr(8'h00, "R10 load");
    step(1, 0, 0); step(1, 0, 0);
    shiftDr(5, 16'b1_1001, 1, 1, 1, "R10 back-to-back");
    chkModes(1, 0, "R10 extest active");

    // R11: five high cycles from inside Shift-DR
    curReq = "R11 shift";
    bsrSerialIn = 1'b0;
    expQ.push_back(1'b0);
    step(1, 0, 0); step(0, 0, 0); step(0, 0, 1);
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    chkModes(0, 0, "R11 reset reached");
    chk("R11 tdoEn", {31'd0, tdoEn}, 0);
    step(0, 0, 0);
    shiftDr(5, 16'b0_0111, 0, 1, 0, "R11 bypass after reset");

    monOn = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule